// File: doc/BRIEF.md
# Handshake-Free Byte Peripheral Bridge

This block connects the word-wide load/store port of a small processor to a narrow peripheral bus that has no ready, acknowledge or wait signalling. It claims one 1 KiB window of the processor address space. Inside that window, a store sends one byte to the peripheral side. The byte goes out with the low address bits and with an output-enable strobe that lasts one clock. A load does not stall the processor and never reaches a device in the same access.

Every in-window access loads the peripheral address register. A load returns the byte that the device presents for the address already held before that access. Software that wants a byte therefore reads the location twice. The first read points the bus at the location, and the second read collects the byte. The returned byte sits in the word lane picked by the two low address bits, and all other lanes are zero. Accesses outside the window do not touch the peripheral side, and loads outside the window return zero.

Top module: `pbus_bridge`

## Requirements
- R1: While rst_n is low at a clock edge, the next outputs are pb_oe = 0, pb_addr = 0, pb_dout = 0 and cpu_rdata = 0.
- R2: An access hits the window when its address lies between 0x80000000 and 0x800003FF inclusive. The addresses 0x7FFFFFFF and 0x80000400 miss.
- R3: A hitting write with the strobe cpu_be[k] set, where k = cpu_addr[1:0], gives pb_addr = cpu_addr[9:0], pb_dout = cpu_wdata[8k+7:8k] and pb_oe = 1 in the cycle after the access. pb_oe returns to 0 in the following cycle unless another write follows.
- R4: A hitting write whose addressed lane strobe cpu_be[k] is clear makes no transfer. pb_oe stays 0, and pb_addr, pb_dout and cpu_rdata stay unchanged.
- R5: pb_oe is 1 only in the cycle after a write request. A read never raises it.
- R6: A hitting read loads pb_addr with cpu_addr[9:0] and leaves pb_dout unchanged.
- R7: A hitting read sets cpu_rdata, from the next cycle on, to the pb_din byte present at the read's clock edge. That byte belongs to the address pb_addr held before the read. It is placed in lane cpu_addr[1:0] (bits 8k+7:8k), and the other lanes are 0. A second read of the same address therefore returns that address's byte.
- R8: A read or write that misses the window leaves pb_addr and pb_dout unchanged and keeps pb_oe at 0. A missing read sets cpu_rdata to 0.
- R9: cpu_rdata changes only after a read request. Idle cycles and writes leave it unchanged.
- R10: When cpu_rd and cpu_wr are both 1, the access is handled as a write only, and cpu_rdata holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor store data, four byte lanes |
| cpu_be | input | 4 | Store byte strobes, one per lane |
| cpu_rd | input | 1 | Load request, one cycle per access |
| cpu_wr | input | 1 | Store request, one cycle per access |
| cpu_rdata | output | 32 | Registered load data |
| pb_addr | output | 10 | Peripheral byte address |
| pb_dout | output | 8 | Peripheral write byte |
| pb_din | input | 8 | Peripheral read byte, sampled on read edges |
| pb_oe | output | 1 | Peripheral write strobe, one clock per write |

## Verification
The bench builds the bridge with its default parameters: a 32-bit processor port, a 10-bit peripheral address and the window base at 0x80000000. With these values the edges of the window can be tested directly. The bench drives the last address below the window, the first and last addresses inside it, and the first address above it. It also exercises all four byte lanes for writes and for returned reads. A bench device model answers as a pure function of pb_addr. This lets the bench predict the stale first read and the correct second read of the two-read scheme.

// File: rtl/pbus_pkg.sv
// Shared types for the byte peripheral bridge.
// Assumes: each processor request lasts a single cycle.
package pbus_pkg;

    // Classified access for the current cycle
    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,  // nothing reaches the peripheral side
        ACC_READ    = 2'd1,  // in-window read: move address, capture byte
        ACC_WRITE   = 2'd2,  // in-window write with its lane strobe set
        ACC_ZERO_RD = 2'd3   // out-of-window read: return zero
    } acc_kind_e;

endpackage

// File: rtl/pbus_decode.sv
// Window decoder and access classifier.
// What it does: checks whether the address falls inside the aligned window
// and sorts the request into one access kind. A write wins over a read.
// Assumes: WIN_BASE is aligned to 2**EXT_AW and DATA_W is a multiple of 8.
module pbus_decode
    import pbus_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              DATA_W   = 32,
    parameter int              EXT_AW   = 10,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W/8-1:0]    be,
    input  logic                   rd,
    input  logic                   wr,
    output logic                   hit,
    output logic [EXT_AW-1:0]      offset,
    output logic [$clog2(DATA_W/8)-1:0] lane,
    output acc_kind_e              kind
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    // Compare the upper address bits against the window base
    always_comb begin
        hit    = (addr[ADDR_W-1:EXT_AW] == WIN_BASE[ADDR_W-1:EXT_AW]);
        offset = addr[EXT_AW-1:0];
        lane   = addr[LANE_W-1:0];
    end

    // Classify the request; a write wins and a masked write is dropped
    always_comb begin
        kind = ACC_IDLE;
        if (wr) begin
            if (hit && be[lane]) kind = ACC_WRITE;
        end else if (rd) begin
            kind = hit ? ACC_READ : ACC_ZERO_RD;
        end
    end

    // R10: a write request never yields a read kind
    always_comb begin
        if (wr) a_r10_write_wins: assert (kind == ACC_IDLE || kind == ACC_WRITE);
    end
endmodule

// File: rtl/pbus_addr_hold.sv
// Peripheral address register.
// What it does: loads the window offset on every in-window read or write
// and holds it otherwise, so a later read samples the addressed device.
// Assumes: kind comes from pbus_decode in the same cycle.
module pbus_addr_hold
    import pbus_pkg::*;
#(
    parameter int EXT_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_kind_e         kind,
    input  logic [EXT_AW-1:0] offset,
    output logic [EXT_AW-1:0] addr_q
);
    // Move the address only on accesses that reach the bus
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (kind == ACC_READ || kind == ACC_WRITE)
            addr_q <= offset;
    end

    // R8 / R4: idle or zero-return accesses keep the held address
    a_r8_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_IDLE || kind == ACC_ZERO_RD) |=> $stable(addr_q));
endmodule

// File: rtl/pbus_wr_strobe.sv
// Write byte selector and output-enable generator.
// What it does: picks the byte lane named by the low address bits, registers
// it onto the data-out bus and raises the strobe for one clock.
// Assumes: kind is ACC_WRITE only when the lane strobe was set.
module pbus_wr_strobe
    import pbus_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  acc_kind_e                      kind,
    input  logic [$clog2(DATA_W/8)-1:0]    lane,
    input  logic [DATA_W-1:0]              wdata,
    output logic [7:0]                     dout_q,
    output logic                           oe_q
);
    localparam int LANES = DATA_W / 8;

    logic [7:0] lane_byte [LANES];
    logic [7:0] pick;

    // Split the store word into its byte lanes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_byte[g] = wdata[8*g +: 8];
    end

    // Select the lane addressed by the low address bits
    always_comb pick = lane_byte[lane];

    // Register data and a single-clock strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            oe_q <= (kind == ACC_WRITE);
            if (kind == ACC_WRITE) dout_q <= pick;
        end
    end

    // R3: a write presents the selected byte next cycle
    a_r3_byte_out: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WRITE) |=> (oe_q && dout_q == $past(pick)));
    // R6 / R8: no write means the data bus holds
    a_r6_dout_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_WRITE) |=> ($stable(dout_q) && !oe_q));
endmodule

// File: rtl/pbus_rd_capture.sv
// Read-return register.
// What it does: on an in-window read it samples the peripheral byte and
// places it in the addressed lane with the other lanes zero. An out-of-window
// read clears the word. All other cycles hold it.
// Assumes: din reflects the address held before the current access.
module pbus_rd_capture
    import pbus_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  acc_kind_e                      kind,
    input  logic [$clog2(DATA_W/8)-1:0]    lane,
    input  logic [7:0]                     din,
    output logic [DATA_W-1:0]              rdata_q
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] placed;
    logic [LANES-1:0]  lane_nz;

    // Build the returned word lane by lane
    for (genvar g = 0; g < LANES; g++) begin : g_place
        assign placed[8*g +: 8] = (lane == g) ? din : 8'h00;
        assign lane_nz[g]       = |rdata_q[8*g +: 8];
    end

    // Capture on reads, clear on missing reads, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (kind == ACC_READ)
            rdata_q <= placed;
        else if (kind == ACC_ZERO_RD)
            rdata_q <= '0;
    end

    // R7: after a read at most one lane carries data
    a_r7_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_READ) |=> $onehot0(lane_nz));
endmodule

// File: rtl/pbus_bridge.sv
// Top of the handshake-free byte peripheral bridge.
// What it does: decodes one window, forwards byte writes with a one-clock
// strobe and returns reads through the two-read scheme (the address moves
// on the first read, and the byte is collected on a later one).
// Assumes: single-cycle requests, and a device that drives pb_din from
// pb_addr without a handshake.
module pbus_bridge
    import pbus_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter int                EXT_AW   = 10,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic [DATA_W/8-1:0] cpu_be,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic [EXT_AW-1:0]   pb_addr,
    output logic [7:0]          pb_dout,
    input  logic [7:0]          pb_din,
    output logic                pb_oe
);
    localparam int LANE_W = $clog2(DATA_W / 8);

    logic              hit;
    logic [EXT_AW-1:0] offset;
    logic [LANE_W-1:0] lane;
    acc_kind_e         kind;

    pbus_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXT_AW(EXT_AW), .WIN_BASE(WIN_BASE)
    ) u_decode (
        .addr(cpu_addr), .be(cpu_be), .rd(cpu_rd), .wr(cpu_wr),
        .hit(hit), .offset(offset), .lane(lane), .kind(kind)
    );

    pbus_addr_hold #(.EXT_AW(EXT_AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .kind(kind), .offset(offset), .addr_q(pb_addr)
    );

    pbus_wr_strobe #(.DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .kind(kind), .lane(lane),
        .wdata(cpu_wdata), .dout_q(pb_dout), .oe_q(pb_oe)
    );

    pbus_rd_capture #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .kind(kind), .lane(lane),
        .din(pb_din), .rdata_q(cpu_rdata)
    );

    // R5: the strobe only follows a write request
    a_r5_oe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        pb_oe |-> $past(cpu_wr));
    // R3: an in-window write drives its offset with the strobe
    a_r3_write_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && hit && cpu_be[lane]) |=> (pb_oe && pb_addr == $past(cpu_addr[EXT_AW-1:0])));
    // R8: misses leave the peripheral address alone
    a_r8_miss_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && !hit) |=> ($stable(pb_addr) && !pb_oe));
    // R8: a missing read returns zero
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && !hit) |=> (cpu_rdata == '0));
    // R9 / R10: read data holds unless a read alone was requested
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd || cpu_wr) |=> $stable(cpu_rdata));
endmodule

// File: tb/sim_pbus_bridge.sv
`timescale 1ns/1ps
module sim_pbus_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_rdata;
    logic [9:0]  pb_addr;
    logic [7:0]  pb_dout;
    logic [7:0]  pb_din;
    logic        pb_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model state
    logic [9:0]  m_addr = '0;
    logic [7:0]  m_dout = '0;
    logic [31:0] m_rdata = '0;

    always #2.5 clk = ~clk;   // 200 MHz

    function automatic logic [7:0] dev_byte(input logic [9:0] a);
        return a[7:0] ^ 8'h5A ^ {6'b0, a[9:8]};
    endfunction

    assign pb_din = dev_byte(pb_addr);

    pbus_bridge u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_be(cpu_be), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .pb_addr(pb_addr), .pb_dout(pb_dout), .pb_din(pb_din), .pb_oe(pb_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access: drive at a falling edge, release at the next
    task automatic access(input logic rd, input logic wr, input logic [31:0] a,
                          input logic [31:0] wd, input logic [3:0] be);
        @(negedge clk);
        cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_be = '0;
    endtask

    task automatic check_all(input string req, input logic oe_exp);
        chk({req, " pb_addr"}, {22'b0, pb_addr}, {22'b0, m_addr});
        chk({req, " pb_dout"}, {24'b0, pb_dout}, {24'b0, m_dout});
        chk({req, " pb_oe"}, {31'b0, pb_oe}, {31'b0, oe_exp});
        chk({req, " cpu_rdata"}, cpu_rdata, m_rdata);
    endtask

    function automatic bit in_win(input logic [31:0] a);
        return a[31:10] == 22'h200000;
    endfunction

    task automatic do_write(input string req, input logic [31:0] a,
                            input logic [31:0] wd, input logic [3:0] be);
        bit go;
        go = in_win(a) && be[a[1:0]];
        access(1'b0, 1'b1, a, wd, be);
        if (go) begin
            m_addr = a[9:0];
            m_dout = wd[8*a[1:0] +: 8];
        end
        check_all(req, go);
        @(negedge clk);
        chk({req, " oe one clock"}, {31'b0, pb_oe}, 32'd0);
    endtask

    task automatic do_read(input string req, input logic [31:0] a);
        if (in_win(a)) begin
            m_rdata = {24'b0, dev_byte(m_addr)} << (8 * a[1:0]);
            m_addr  = a[9:0];
        end else begin
            m_rdata = '0;
        end
        access(1'b1, 1'b0, a, 32'h0, 4'h0);
        check_all(req, 1'b0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check_all("R1 reset", 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_write_lanes;
        for (int k = 0; k < 4; k++)
            do_write("R3 write lane", 32'h8000_0120 + k, 32'hD4C3_B2A1 + (k << 4), 4'b1 << k);
        do_write("R3 write all strobes", 32'h8000_0002, 32'h1122_3344, 4'hF);
    endtask

    task automatic t_write_masked;
        do_write("R4 masked write", 32'h8000_0041, 32'hFFFF_FFFF, 4'b1101);
    endtask

    task automatic t_read_pair;
        do_write("R3 setup", 32'h8000_0010, 32'hAA, 4'h1);
        do_read("R7 first read stale", 32'h8000_0233);
        do_read("R7 second read", 32'h8000_0233);
        do_read("R6 read moves addr", 32'h8000_0001);
        do_read("R7 lane1", 32'h8000_0001);
        do_read("R7 lane2", 32'h8000_0002);
        do_read("R7 lane2 again", 32'h8000_0002);
    endtask

    task automatic t_bounds;
        do_read("R2 last in window", 32'h8000_03FF);
        do_read("R2 last in window again", 32'h8000_03FF);
        do_read("R2 first in window", 32'h8000_0000);
        do_read("R2 above window", 32'h8000_0400);
        do_read("R2 below window", 32'h7FFF_FFFF);
        do_read("R2 first in window again", 32'h8000_0000);
    endtask

    task automatic t_outside;
        do_read("R8 setup", 32'h8000_0155);
        do_write("R8 write outside", 32'h8000_0800, 32'h77, 4'hF);
        do_write("R8 write far", 32'h0000_0003, 32'h66, 4'hF);
        do_read("R8 read outside zero", 32'h9000_0001);
    endtask

    task automatic t_hold;
        do_read("R9 setup", 32'h8000_0155);
        do_read("R9 setup2", 32'h8000_0155);
        repeat (4) @(negedge clk);
        chk("R9 idle hold", cpu_rdata, m_rdata);
        do_write("R9 write keeps rdata", 32'h8000_0003, 32'h9900_0000, 4'h8);
        chk("R5 no oe idle", {31'b0, pb_oe}, 32'd0);
    endtask

    task automatic t_both;
        access(1'b1, 1'b1, 32'h8000_0202, 32'h00EE_0000, 4'h4);
        m_addr = 10'h202; m_dout = 8'hEE;
        check_all("R10 both requests", 1'b1);
        access(1'b1, 1'b1, 32'h8000_0301, 32'h0, 4'h0);
        check_all("R10 both masked", 1'b0);
    endtask

    initial begin
        t_reset;
        t_write_lanes;
        t_write_masked;
        t_read_pair;
        t_bounds;
        t_outside;
        t_hold;
        t_both;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule